// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block sits in the feedback path of a fractional-N frequency loop. It divides a fast input clock by an average ratio of INT + FRAC/MOD and emits one short feedback pulse per divided period. The ratio of every single period is a whole number. A first-order fractional accumulator decides, period by period, whether that ratio is INT or INT+1, so that the long-run average lands on the fractional target.

Internally, the integer ratio of each period is produced the way a dual-modulus prescaler loop produces it. A prescaler model counts input clocks in groups of P or P+1. A main counter counts prescaler cycles, and a swallow counter marks how many of those cycles use P+1. The prescaler core runs in 4/5 or 8/9 mode. Each mode has its own smallest legal integer ratio, and the ratio inputs are clamped against it. New ratio inputs are sampled only when one period ends and the next is loaded. Software can therefore change them at any time without producing a runt period.

Top module: `fnd_top`

## Requirements
- R1: With FRAC = 0, consecutive rising edges of `fb_pulse` are exactly INT input clocks apart.
- R2: `fb_pulse` is high for exactly one input clock at the end of each divided period.
- R3: At each period end the accumulator adds FRAC. If the sum is greater than or equal to MOD, MOD is subtracted and the next period lasts INT+1 clocks; otherwise it lasts INT clocks. Over MOD consecutive periods after a counter reset, exactly FRAC periods are INT+1 long.
- R4: With `pre_sel` = 0 (4/5 mode), an INT below 31 raises `int_err` and the period length becomes 31.
- R5: With `pre_sel` = 1 (8/9 mode), an INT below 91 raises `int_err` and the period length becomes 91. At or above the mode's minimum, `int_err` is low.
- R6: A FRAC greater than MOD raises `frac_err` and is treated as equal to MOD. With FRAC equal to MOD, every period is INT+1 long and `frac_err` is low.
- R7: A MOD of zero disables the fractional part, so every period is INT clocks long.
- R8: While `cnt_rst` is high, no pulse is produced and the accumulator is cleared. The first pulse after release comes INT clocks after the last clock edge that sampled `cnt_rst` high, and that first period carries no fractional extension.
- R9: INT, FRAC, MOD and `pre_sel` are sampled only at the clock edge that ends a period. A change in the middle of a period does not alter that period's length.
- R10: While `rst_n` is low, `fb_pulse` is low. After release, the first period is INT clocks long.
- R11: The prescaler mode does not change the division ratio. An INT that is legal in both modes gives the same period length in each, up to the largest ratio of 512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_rst | input | 1 | Holds counters and accumulator in their initial state while high |
| int_val | input | 9 | Integer part of the division ratio |
| frac_val | input | 12 | Fractional numerator |
| mod_val | input | 12 | Fractional modulus (denominator) |
| pre_sel | input | 1 | Prescaler mode: 0 = 4/5, 1 = 8/9 |
| fb_pulse | output | 1 | One-clock feedback pulse at the end of each period |
| int_err | output | 1 | INT is below the minimum for the selected mode |
| frac_err | output | 1 | FRAC is above MOD |

## Verification
The bench builds the block with its default parameters: a 9-bit integer, a 12-bit fraction and modulus, a 4/5 core with an 8/9 option, and minima of 31 and 91. These values put both clamping floors within reach, together with the largest ratio of 512 at its widest main count of 128 prescaler cycles. With small moduli such as 4 and 7, complete carry patterns of the accumulator fit into a few thousand clocks, so the period sums can be compared exactly against the INT·MOD + FRAC total.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

  localparam int unsigned DEF_INT_W    = 9;
  localparam int unsigned DEF_FRAC_W   = 12;
  localparam int unsigned DEF_PL_LOG2  = 2;
  localparam int unsigned DEF_NMIN_LO  = 31;
  localparam int unsigned DEF_NMIN_HI  = 91;

  typedef enum logic {
    PS_LOW  = 1'b0,
    PS_HIGH = 1'b1
  } ps_mode_e;

endpackage

// File: rtl/fnd_ratio.sv
module fnd_ratio
  import fnd_pkg::*;
#(
  parameter int unsigned INT_W   = DEF_INT_W,
  parameter int unsigned FRAC_W  = DEF_FRAC_W,
  parameter int unsigned PL_LOG2 = DEF_PL_LOG2,
  parameter int unsigned NMIN_LO = DEF_NMIN_LO,
  parameter int unsigned NMIN_HI = DEF_NMIN_HI,
  localparam int unsigned N_W    = INT_W + 1,
  localparam int unsigned S_W    = PL_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              restart,
  input  logic              period_end,
  input  logic [INT_W-1:0]  int_val,
  input  logic [FRAC_W-1:0] frac_val,
  input  logic [FRAC_W-1:0] mod_val,
  input  logic              pre_sel,
  output logic              int_err,
  output logic              frac_err,
  output logic [N_W-1:0]    ld_main,
  output logic [S_W-1:0]    ld_swal,
  output logic              ld_hi,
  output logic              p_hi_q
);

  localparam logic [N_W-1:0] MASK_LO = N_W'((1 << PL_LOG2) - 1);
  localparam logic [N_W-1:0] MASK_HI = N_W'((1 << (PL_LOG2 + 1)) - 1);

  ps_mode_e            mode;
  logic [INT_W-1:0]    nmin;
  logic [INT_W-1:0]    int_c;
  logic [FRAC_W-1:0]   frac_c;
  logic [FRAC_W:0]     sum;
  logic                wrap;
  logic                carry;
  logic [N_W-1:0]      n_eff;
  logic [FRAC_W-1:0]   acc_q;
  logic [FRAC_W-1:0]   acc_d;
  logic                acc_en;
  logic                p_hi_d;

  // operand conditioning
  always_comb begin
    mode     = pre_sel ? PS_HIGH : PS_LOW;
    nmin     = (mode == PS_HIGH) ? INT_W'(NMIN_HI) : INT_W'(NMIN_LO);
    int_err  = int_val < nmin;
    int_c    = int_err ? nmin : int_val;
    frac_err = frac_val > mod_val;
    frac_c   = frac_err ? mod_val : frac_val;
  end

  // first-order accumulator step and ratio split
  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, frac_c};
    wrap    = (mod_val != '0) && (sum >= {1'b0, mod_val});
    carry   = period_end && !restart && wrap;
    n_eff   = {1'b0, int_c} + N_W'(carry);
    if (mode == PS_HIGH) begin
      ld_main = n_eff >> (PL_LOG2 + 1);
      ld_swal = S_W'(n_eff & MASK_HI);
    end else begin
      ld_main = n_eff >> PL_LOG2;
      ld_swal = S_W'(n_eff & MASK_LO);
    end
    ld_hi   = ld_swal != '0;
  end

  // next state
  always_comb begin
    acc_en = restart || period_end;
    if (restart) begin
      acc_d = '0;
    end else if (wrap) begin
      acc_d = FRAC_W'(sum - {1'b0, mod_val});
    end else begin
      acc_d = FRAC_W'(sum);
    end
    p_hi_d = (mode == PS_HIGH);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      p_hi_q <= 1'b0;
    end else begin
      if (acc_en) begin
        acc_q <= acc_d;
      end
      if (load) begin
        p_hi_q <= p_hi_d;
      end
    end
  end

endmodule

// File: rtl/fnd_prescaler.sv
module fnd_prescaler
  import fnd_pkg::*;
#(
  parameter int unsigned PL_LOG2 = DEF_PL_LOG2,
  localparam int unsigned PC_W   = PL_LOG2 + 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic ld_hi,
  input  logic nxt_hi,
  input  logic p_hi,
  output logic tick
);

  localparam logic [PC_W-1:0] LAST_LO = PC_W'((1 << PL_LOG2) - 1);
  localparam logic [PC_W-1:0] LAST_HI = PC_W'((1 << (PL_LOG2 + 1)) - 1);

  logic [PC_W-1:0] cnt_q;
  logic [PC_W-1:0] cnt_d;
  logic            hi_q;
  logic            hi_d;
  logic [PC_W-1:0] last;

  always_comb begin
    last = (p_hi ? LAST_HI : LAST_LO) + PC_W'(hi_q);
    tick = (cnt_q == last);
  end

  always_comb begin
    if (load) begin
      cnt_d = '0;
      hi_d  = ld_hi;
    end else if (tick) begin
      cnt_d = '0;
      hi_d  = nxt_hi;
    end else begin
      cnt_d = cnt_q + PC_W'(1);
      hi_d  = hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
    end
  end

endmodule

// File: rtl/fnd_swallow.sv
module fnd_swallow
  import fnd_pkg::*;
#(
  parameter int unsigned N_W = DEF_INT_W + 1,
  parameter int unsigned S_W = DEF_PL_LOG2 + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           tick,
  input  logic [N_W-1:0] ld_main,
  input  logic [S_W-1:0] ld_swal,
  output logic           period_end,
  output logic           idle,
  output logic           nxt_hi,
  output logic [N_W-1:0] main_left,
  output logic [S_W-1:0] swal_left
);

  logic [N_W-1:0] main_d;
  logic [S_W-1:0] swal_d;
  logic           cnt_en;

  always_comb begin
    idle       = (main_left == '0);
    period_end = tick && (main_left == N_W'(1));
    nxt_hi     = swal_left > S_W'(1);
  end

  always_comb begin
    cnt_en = load || tick;
    if (load) begin
      main_d = ld_main;
      swal_d = ld_swal;
    end else begin
      main_d = main_left - N_W'(1);
      swal_d = (swal_left != '0) ? swal_left - S_W'(1) : swal_left;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_left <= '0;
      swal_left <= '0;
    end else if (cnt_en) begin
      main_left <= main_d;
      swal_left <= swal_d;
    end
  end

endmodule

// File: rtl/fnd_top.sv
module fnd_top
  import fnd_pkg::*;
#(
  parameter int unsigned INT_W   = DEF_INT_W,
  parameter int unsigned FRAC_W  = DEF_FRAC_W,
  parameter int unsigned PL_LOG2 = DEF_PL_LOG2,
  parameter int unsigned NMIN_LO = DEF_NMIN_LO,
  parameter int unsigned NMIN_HI = DEF_NMIN_HI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_rst,
  input  logic [INT_W-1:0]  int_val,
  input  logic [FRAC_W-1:0] frac_val,
  input  logic [FRAC_W-1:0] mod_val,
  input  logic              pre_sel,
  output logic              fb_pulse,
  output logic              int_err,
  output logic              frac_err
);

  localparam int unsigned N_W = INT_W + 1;
  localparam int unsigned S_W = PL_LOG2 + 1;

  logic           load;
  logic           restart;
  logic           period_end;
  logic           idle;
  logic           tick;
  logic           nxt_hi;
  logic           ld_hi;
  logic           p_hi_q;
  logic [N_W-1:0] ld_main;
  logic [S_W-1:0] ld_swal;
  logic [N_W-1:0] main_left;
  logic [S_W-1:0] swal_left;
  logic           pulse_d;

  always_comb begin
    restart = cnt_rst || idle;
    load    = restart || period_end;
    pulse_d = period_end && !cnt_rst;
  end

  fnd_ratio #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W),
    .PL_LOG2(PL_LOG2),
    .NMIN_LO(NMIN_LO),
    .NMIN_HI(NMIN_HI)
  ) u_ratio (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .restart   (restart),
    .period_end(period_end),
    .int_val   (int_val),
    .frac_val  (frac_val),
    .mod_val   (mod_val),
    .pre_sel   (pre_sel),
    .int_err   (int_err),
    .frac_err  (frac_err),
    .ld_main   (ld_main),
    .ld_swal   (ld_swal),
    .ld_hi     (ld_hi),
    .p_hi_q    (p_hi_q)
  );

  fnd_prescaler #(
    .PL_LOG2(PL_LOG2)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .ld_hi (ld_hi),
    .nxt_hi(nxt_hi),
    .p_hi  (p_hi_q),
    .tick  (tick)
  );

  fnd_swallow #(
    .N_W(N_W),
    .S_W(S_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .tick      (tick),
    .ld_main   (ld_main),
    .ld_swal   (ld_swal),
    .period_end(period_end),
    .idle      (idle),
    .nxt_hi    (nxt_hi),
    .main_left (main_left),
    .swal_left (swal_left)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_pulse <= 1'b0;
    end else begin
      fb_pulse <= pulse_d;
    end
  end

endmodule

// File: rtl/fnd_checker.sv
module fnd_checker #(
  parameter int unsigned N_W     = 10,
  parameter int unsigned S_W     = 3,
  parameter int unsigned NMIN_LO = 31
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cnt_rst,
  input logic           fb_pulse,
  input logic           load,
  input logic           tick,
  input logic [N_W-1:0] main_left,
  input logic [S_W-1:0] swal_left
);

  logic [15:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (fb_pulse) begin
      gap_q <= 16'd1;
    end else if (gap_q != 16'hFFFF) begin
      gap_q <= gap_q + 16'd1;
    end
  end

  assert_single_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  assert_quiet_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> !fb_pulse);

  assert_gap_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> (gap_q >= 16'(NMIN_LO)));

  assert_swallow_fits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (main_left != '0) |-> (N_W'(swal_left) <= main_left));

  assert_counts_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> ($stable(main_left) && $stable(swal_left)));

endmodule

bind fnd_top fnd_checker #(
  .N_W    (N_W),
  .S_W    (S_W),
  .NMIN_LO(NMIN_LO)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_rst  (cnt_rst),
  .fb_pulse (fb_pulse),
  .load     (load),
  .tick     (tick),
  .main_left(main_left),
  .swal_left(swal_left)
);

// File: tb/sim_fnd_top.sv
`timescale 1ns/1ps
module sim_fnd_top;

  logic        clk;
  logic        rst_n;
  logic        cnt_rst;
  logic [8:0]  int_val;
  logic [11:0] frac_val;
  logic [11:0] mod_val;
  logic        pre_sel;
  logic        fb_pulse;
  logic        int_err;
  logic        frac_err;

  int    total;
  int    bad;
  bit    done;
  string cur_req;

  // behavioural reference state
  int m_left;
  int m_acc;
  bit m_started;
  bit m_pulse;

  fnd_top u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_rst (cnt_rst),
    .int_val (int_val),
    .frac_val(frac_val),
    .mod_val (mod_val),
    .pre_sel (pre_sel),
    .fb_pulse(fb_pulse),
    .int_err (int_err),
    .frac_err(frac_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int floor_of();
    return pre_sel ? 91 : 31;
  endfunction

  function automatic int eff_int();
    int f = floor_of();
    return (int'(int_val) < f) ? f : int'(int_val);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_started = 1'b0;
      m_pulse   = 1'b0;
      m_acc     = 0;
      m_left    = 0;
    end else if (cnt_rst || !m_started) begin
      m_started = 1'b1;
      m_pulse   = 1'b0;
      m_acc     = 0;
      m_left    = eff_int();
    end else begin
      m_left = m_left - 1;
      if (m_left == 0) begin
        int fc;
        int s;
        int c;
        m_pulse = 1'b1;
        fc = (frac_val > mod_val) ? int'(mod_val) : int'(frac_val);
        s  = m_acc + fc;
        c  = 0;
        if (mod_val != 0 && s >= int'(mod_val)) begin
          s = s - int'(mod_val);
          c = 1;
        end
        m_acc  = s;
        m_left = eff_int() + c;
      end else begin
        m_pulse = 1'b0;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R10 pulse low in reset", int'(fb_pulse), 0);
      end else if (m_started) begin
        chk({cur_req, " pulse vs model"}, int'(fb_pulse), int'(m_pulse));
        chk("R4/R5 int_err", int'(int_err), int'(int'(int_val) < floor_of()));
        chk("R6 frac_err", int'(frac_err), int'(frac_val > mod_val));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic set_in(int iv, int fv, int mv, bit ps);
    @(negedge clk);
    #1;
    int_val  = 9'(iv);
    frac_val = 12'(fv);
    mod_val  = 12'(mv);
    pre_sel  = ps;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!fb_pulse);
  endtask

  task automatic gap(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!fb_pulse);
  endtask

  task automatic hold_counters();
    @(negedge clk);
    #1 cnt_rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 no pulse during counter reset", int'(fb_pulse), 0);
    end
    #1 cnt_rst = 1'b0;
  endtask

  initial begin
    int g;
    int acc_sum;
    total    = 0;
    bad      = 0;
    done     = 1'b0;
    cur_req  = "R1";
    rst_n    = 1'b0;
    cnt_rst  = 1'b0;
    int_val  = 9'd40;
    frac_val = 12'd0;
    mod_val  = 12'd100;
    pre_sel  = 1'b0;

    // R10: reset state, then first period length
    repeat (4) @(negedge clk);
    chk("R10 fb_pulse during reset", int'(fb_pulse), 0);
    chk("R10 int_err with legal INT", int'(int_err), 0);
    #1 rst_n = 1'b1;
    gap(g);
    chk("R10 first period after reset", g, 41);

    // R1: integer division
    gap(g);
    chk("R1 integer period 40", g, 40);
    gap(g);
    chk("R2 spacing still 40", g, 40);
    @(negedge clk);
    chk("R2 pulse one clock wide", int'(fb_pulse), 0);

    // R8: counter reset and first period
    cur_req = "R8";
    hold_counters();
    gap(g);
    chk("R8 first period after release", g, 40);

    // R3: fractional carry patterns
    cur_req = "R3";
    set_in(50, 1, 4, 1'b0);
    hold_counters();
    gap(g);
    chk("R3 first period carries nothing", g, 50);
    acc_sum = 0;
    for (int i = 0; i < 8; i++) begin
      gap(g);
      acc_sum += g;
    end
    chk("R3 eight periods with 1/4", acc_sum, 402);
    set_in(50, 3, 7, 1'b0);
    hold_counters();
    gap(g);
    acc_sum = 0;
    for (int i = 0; i < 7; i++) begin
      gap(g);
      acc_sum += g;
    end
    chk("R3 seven periods with 3/7", acc_sum, 353);

    // R6: FRAC above or equal to MOD
    cur_req = "R6";
    set_in(50, 200, 100, 1'b0);
    @(negedge clk);
    chk("R6 frac_err raised", int'(frac_err), 1);
    wait_pulse();
    gap(g);
    chk("R6 clamped FRAC gives INT+1", g, 51);
    set_in(50, 100, 100, 1'b0);
    @(negedge clk);
    chk("R6 frac_err low when equal", int'(frac_err), 0);
    wait_pulse();
    gap(g);
    chk("R6 FRAC equal MOD gives INT+1", g, 51);

    // R7: zero modulus
    cur_req = "R7";
    set_in(50, 0, 0, 1'b0);
    wait_pulse();
    gap(g);
    chk("R7 zero modulus integer only", g, 50);
    gap(g);
    chk("R7 zero modulus again", g, 50);

    // R4: 4/5 floor
    cur_req = "R4";
    set_in(20, 0, 0, 1'b0);
    @(negedge clk);
    chk("R4 int_err below 31", int'(int_err), 1);
    wait_pulse();
    gap(g);
    chk("R4 clamped to 31", g, 31);
    set_in(31, 0, 0, 1'b0);
    @(negedge clk);
    chk("R4 int_err at 31", int'(int_err), 0);
    wait_pulse();
    gap(g);
    chk("R4 period at floor", g, 31);

    // R5: 8/9 floor
    cur_req = "R5";
    set_in(60, 0, 0, 1'b1);
    @(negedge clk);
    chk("R5 int_err below 91", int'(int_err), 1);
    wait_pulse();
    gap(g);
    chk("R5 clamped to 91", g, 91);
    set_in(91, 0, 0, 1'b1);
    @(negedge clk);
    chk("R5 int_err at 91", int'(int_err), 0);
    wait_pulse();
    gap(g);
    chk("R5 period at floor", g, 91);

    // R11: mode independence
    cur_req = "R11";
    set_in(100, 0, 0, 1'b1);
    wait_pulse();
    gap(g);
    chk("R11 ratio 100 in 8/9", g, 100);
    set_in(100, 0, 0, 1'b0);
    wait_pulse();
    gap(g);
    chk("R11 ratio 100 in 4/5", g, 100);
    set_in(511, 1, 1, 1'b0);
    wait_pulse();
    gap(g);
    chk("R11 ratio 512 in 4/5", g, 512);
    set_in(511, 1, 1, 1'b1);
    wait_pulse();
    gap(g);
    chk("R11 ratio 512 in 8/9", g, 512);

    // R9: mid-period change is deferred
    cur_req = "R9";
    set_in(40, 0, 0, 1'b0);
    wait_pulse();
    wait_pulse();
    g = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      g++;
    end
    #1 int_val = 9'd60;
    do begin
      @(negedge clk);
      g++;
    end while (!fb_pulse);
    chk("R9 running period keeps old ratio", g, 40);
    gap(g);
    chk("R9 new ratio after boundary", g, 60);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule